// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block steps one successive-approximation conversion. A rising edge on the convert strobe, seen while the block is idle, starts a conversion. The block clears a trial word, sets its top bit and drives that word to an external DAC. After a set number of clock cycles it samples a one-bit comparator decision. The decision keeps or clears the bit under test, and the next lower bit is then set. This repeats down to the least significant bit. The finished word is then copied into an output latch, and a one-cycle done pulse marks the update.

The analog parts (DAC, comparator, reference) sit outside the block. The caller picks the result format at the moment of the start edge: straight binary for unipolar inputs, or two's complement for bipolar inputs. Two's complement is formed by inverting the top bit of the offset-binary word. The resolution (`RES_BITS`, 12 or 16) and the cycles spent on each bit (`CYC_PER_BIT`) are parameters. Together they fix the conversion length at `RES_BITS*CYC_PER_BIT+1` clock cycles, and the clock rate is chosen so that this length fits the conversion time budget.

The state machine has three states. IDLE waits for a start edge. TRIAL holds one bit under test per `CYC_PER_BIT` cycles. LATCH writes the output latch. The transitions are: IDLE to TRIAL on a start edge (start), TRIAL to TRIAL on each bit decision except the last one (step), TRIAL to LATCH on the decision for bit 0 (finish), and LATCH to IDLE unconditionally (publish).

Top module: `sar_seq_top`

## Requirements
- R1: After reset `busy_o`, `done_o`, `dac_code_o`, `result_o` and `result_bipolar_o` are all 0.
- R2: A conversion starts only on a low-to-high transition of `conv_i` sampled in IDLE. `busy_o` is 1 at the first clock edge after that transition. A level held high, including one held through reset, starts nothing.
- R3: A rising edge of `conv_i` during a conversion is ignored. The running conversion is neither restarted nor lengthened.
- R4: Bit k (from RES_BITS-1 down to 0) is under test for exactly CYC_PER_BIT cycles. While it is under test, `dac_code_o` holds the decided bits above k, a 1 at bit k and zeros below k. The decision taken at the end of that window keeps bit k when `cmp_i`=1 (input at or above the trial code) and clears it otherwise.
- R5: In unipolar format the latched result equals the input code that an ideal comparator resolves, in straight binary.
- R6: In bipolar format the latched result is that same word with its top bit inverted (two's complement), and `result_bipolar_o` is 1.
- R7: The format is sampled from `bipolar_i` only at the start edge. A change of `bipolar_i` during a conversion does not affect that conversion's result.
- R8: `busy_o` stays high for exactly RES_BITS*CYC_PER_BIT+1 cycles. `done_o` is a single-cycle pulse in the first cycle after `busy_o` falls, which is the cycle in which `result_o` shows the new word.
- R9: `result_o` and `result_bipolar_o` keep their previous values for the whole of a conversion.
- R10: A rising edge of `conv_i` sampled in the LATCH cycle (the last busy cycle) is ignored. A `conv_i` left high after that starts nothing until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_i | input | 1 | Convert strobe; rising edge starts a conversion |
| bipolar_i | input | 1 | Result format select: 1 two's complement, 0 straight binary |
| cmp_i | input | 1 | Comparator decision: 1 when input is at or above `dac_code_o` |
| dac_code_o | output | RES_BITS | Trial code driven to the DAC |
| busy_o | output | 1 | High while a conversion runs |
| done_o | output | 1 | One-cycle pulse when the output latch updates |
| result_o | output | RES_BITS | Latched conversion result |
| result_bipolar_o | output | 1 | Format of the latched result |

## Verification
The tightest coincidence is a new start edge that lands in the LATCH cycle, where the output latch is being written. The bench raises the strobe at exactly that edge. It then checks three things: the finished result is the one from the conversion in progress, `busy_o` stays low for several cycles although the strobe remains high, and only a fresh low-to-high transition afterwards starts the next conversion. A second overlap is a strobe edge or a format change in the middle of a bit window. Both are judged by the total busy length and by the word and format that end up in the latch.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIAL = 2'd1,
        ST_LATCH = 2'd2
    } sar_state_e;
endpackage

// File: rtl/sar_rise_det.sv
module sar_rise_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= RST_VAL;
        else         lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i && !lvl_q;
endmodule

// File: rtl/sar_bit_timer.sv
module sar_bit_timer #(
    parameter int CYC_PER_BIT = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (CYC_PER_BIT > 2) ? $clog2(CYC_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (!run_i)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int W = 16
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 load_i,
    input  logic                 step_i,
    input  logic                 cmp_i,
    output logic [W-1:0]         trial_o,
    output logic [$clog2(W)-1:0] idx_o,
    output logic                 last_o
);
    localparam int IW = $clog2(W);

    logic [W-1:0]  trial_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trial_q <= '0;
            idx_q   <= '0;
        end else if (load_i) begin
            trial_q <= {1'b1, {(W-1){1'b0}}};
            idx_q   <= IW'(W - 1);
        end else if (step_i) begin
            for (int i = 0; i < W; i++) begin
                if (i == int'(idx_q))          trial_q[i] <= cmp_i;
                else if (i + 1 == int'(idx_q)) trial_q[i] <= 1'b1;
            end
            if (idx_q != '0) idx_q <= idx_q - 1'b1;
        end
    end

    assign trial_o = trial_q;
    assign idx_o   = idx_q;
    assign last_o  = (idx_q == '0);
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS    = 16,
    parameter int CYC_PER_BIT = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                conv_i,
    input  logic                bipolar_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                result_bipolar_o
);
    localparam int IDX_W = $clog2(RES_BITS);
    localparam int MSB   = RES_BITS - 1;

    sar_state_e          state, state_nxt;
    logic                start_rise;
    logic                bit_tick;
    logic                last_bit;
    logic                fmt_q;
    logic                res_fmt_q;
    logic                done_q;
    logic [RES_BITS-1:0] trial;
    logic [RES_BITS-1:0] result_q;
    logic [IDX_W-1:0]    bit_idx;
    logic                do_start;
    logic                do_step;

    assign do_start = (state == ST_IDLE) && start_rise;
    assign do_step  = (state == ST_TRIAL) && bit_tick;

    sar_rise_det #(.RST_VAL(1'b1)) u_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (conv_i),
        .rise_o (start_rise)
    );

    sar_bit_timer #(.CYC_PER_BIT(CYC_PER_BIT)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (state == ST_TRIAL),
        .tick_o (bit_tick)
    );

    sar_trial_reg #(.W(RES_BITS)) u_trial (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (do_start),
        .step_i  (do_step),
        .cmp_i   (cmp_i),
        .trial_o (trial),
        .idx_o   (bit_idx),
        .last_o  (last_bit)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state <= ST_IDLE;
        else         state <= state_nxt;
    end

    // transitions: start, step, finish, publish
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start_rise)            state_nxt = ST_TRIAL;
            ST_TRIAL: if (bit_tick && last_bit)  state_nxt = ST_LATCH;
            ST_LATCH:                            state_nxt = ST_IDLE;
            default:                             state_nxt = ST_IDLE;
        endcase
    end

    // format capture and output latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fmt_q     <= 1'b0;
            res_fmt_q <= 1'b0;
            result_q  <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (do_start) fmt_q <= bipolar_i;
            if (state == ST_LATCH) begin
                result_q  <= {trial[MSB] ^ fmt_q, trial[MSB-1:0]};
                res_fmt_q <= fmt_q;
                done_q    <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o           = (state != ST_IDLE);
        dac_code_o       = (state == ST_IDLE) ? '0 : trial;
        done_o           = done_q;
        result_o         = result_q;
        result_bipolar_o = res_fmt_q;
    end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_BITS    = 16,
    parameter int CYC_PER_BIT = 4
) (
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic                         conv_i,
    input logic                         busy_i,
    input logic                         done_i,
    input logic [RES_BITS-1:0]          dac_code_i,
    input logic [RES_BITS-1:0]          result_i,
    input logic                         trial_i,
    input logic [$clog2(RES_BITS)-1:0]  bit_idx_i,
    input logic                         fmt_i
);
    localparam int CONV_CYCLES = RES_BITS * CYC_PER_BIT + 1;
    localparam int CNT_W       = $clog2(CONV_CYCLES + 2);

    logic [CNT_W-1:0]    busy_cnt;
    logic [RES_BITS-1:0] low_mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     busy_cnt <= '0;
        else if (busy_i) busy_cnt <= busy_cnt + 1'b1;
        else             busy_cnt <= '0;
    end

    assign low_mask = (RES_BITS'(1) << bit_idx_i) - RES_BITS'(1);

    // R2
    start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_i) |-> $past(conv_i));

    // R3
    no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i)) |-> (bit_idx_i <= $past(bit_idx_i)));

    // R4
    trial_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trial_i |-> (dac_code_i[bit_idx_i] && ((dac_code_i & low_mask) == '0)));

    // R7
    fmt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i)) |-> $stable(fmt_i));

    // R8
    busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> (busy_cnt < CNT_W'(CONV_CYCLES)));

    // R8
    done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> (busy_cnt == CNT_W'(CONV_CYCLES)));

    // R8
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i);

    // R9
    result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && $past(busy_i)) |-> $stable(result_i));
endmodule

bind sar_seq_top sar_seq_chk #(
    .RES_BITS    (RES_BITS),
    .CYC_PER_BIT (CYC_PER_BIT)
) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .conv_i     (conv_i),
    .busy_i     (busy_o),
    .done_i     (done_o),
    .dac_code_i (dac_code_o),
    .result_i   (result_o),
    .trial_i    (state == sar_seq_pkg::ST_TRIAL),
    .bit_idx_i  (bit_idx),
    .fmt_i      (fmt_q)
);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
    localparam int N    = 16;
    localparam int C    = 4;
    localparam int CONV = N * C + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_r = 1'b0;
    logic          bip_r = 1'b0;
    logic [N-1:0]  vin_r = '0;
    logic          cmp;
    logic [N-1:0]  dac_code;
    logic          busy;
    logic          done;
    logic [N-1:0]  result;
    logic          result_bip;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    assign cmp = (vin_r >= dac_code);

    sar_seq_top #(.RES_BITS(N), .CYC_PER_BIT(C)) dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .conv_i           (conv_r),
        .bipolar_i        (bip_r),
        .cmp_i            (cmp),
        .dac_code_o       (dac_code),
        .busy_o           (busy),
        .done_o           (done),
        .result_o         (result),
        .result_bipolar_o (result_bip)
    );

    // {bipolar, input code, expected result}
    localparam logic [32:0] VEC [0:6] = '{
        {1'b0, 16'h0000, 16'h0000},
        {1'b0, 16'hFFFF, 16'hFFFF},
        {1'b0, 16'h8000, 16'h8000},
        {1'b0, 16'hA5A5, 16'hA5A5},
        {1'b1, 16'h1234, 16'h9234},
        {1'b1, 16'h8000, 16'h0000},
        {1'b1, 16'h7FFF, 16'hFFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // one conversion; retrig_at / flip_at are negedge counts inside the run (-1 = off)
    task automatic run_conv(input logic [N-1:0] vin, input logic bip, input bit trace,
                            input int retrig_at, input int flip_at, output int busy_cyc);
        logic [N-1:0] prev_res;
        logic         prev_fmt;
        int c;
        prev_res = result;
        prev_fmt = result_bip;
        @(negedge clk);
        vin_r  = vin;
        bip_r  = bip;
        conv_r = 1'b1;
        c = 0;
        while (c < 1000) begin
            @(negedge clk);
            c++;
            if (c == 1) begin
                conv_r = 1'b0;
                check("R2 busy after edge", 32'(busy), 32'd1);
            end
            if (!busy) break;
            if (trace && (c - 1) < N * C) begin
                int k;
                logic [31:0] exp_code;
                k = N - 1 - (c - 1) / C;
                exp_code = (32'(vin) & ~((32'd1 << (k + 1)) - 1)) | (32'd1 << k);
                check("R4 trial code", 32'(dac_code), exp_code);
            end
            if (c == 2 || c == CONV) begin
                check("R9 result held", 32'(result), 32'(prev_res));
                check("R9 format held", 32'(result_bip), 32'(prev_fmt));
            end
            if (c == retrig_at) conv_r = 1'b1;
            if (c == retrig_at + 1) conv_r = 1'b0;
            if (c == flip_at) bip_r = ~bip_r;
        end
        busy_cyc = c - 1;
        check("R8 done with new result", 32'(done), 32'd1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cyc;
        conv_r = 1'b1;                       // level held high through reset
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 dac", 32'(dac_code), 32'd0);
        check("R1 result", 32'(result), 32'd0);
        check("R1 format", 32'(result_bip), 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R2 high level no start", 32'(busy), 32'd0);
        conv_r = 1'b0;
        @(negedge clk);

        // vector table: R5 unipolar, R6 bipolar
        for (int i = 0; i < 7; i++) begin
            run_conv(VEC[i][31:16], VEC[i][32], 1'b0, -1, -1, cyc);
            check(VEC[i][32] ? "R6 result" : "R5 result", 32'(result), 32'(VEC[i][15:0]));
            check(VEC[i][32] ? "R6 format" : "R5 format", 32'(result_bip), 32'(VEC[i][32]));
            check("R8 busy length", cyc, CONV);
            @(negedge clk);
            check("R8 done one cycle", 32'(done), 32'd0);
        end

        // R4 bit order trace
        run_conv(16'h5C3A, 1'b0, 1'b1, -1, -1, cyc);
        check("R5 traced result", 32'(result), 32'h5C3A);

        // R3 retrigger mid conversion
        run_conv(16'h0F0F, 1'b0, 1'b0, 20, -1, cyc);
        check("R3 no restart length", cyc, CONV);
        check("R3 result kept", 32'(result), 32'h0F0F);
        @(negedge clk);
        check("R3 idle after", 32'(busy), 32'd0);

        // R7 format flip mid conversion
        run_conv(16'h1234, 1'b0, 1'b0, -1, 30, cyc);
        check("R7 result unipolar", 32'(result), 32'h1234);
        check("R7 format unipolar", 32'(result_bip), 32'd0);
        run_conv(16'h1234, 1'b1, 1'b0, -1, 5, cyc);
        check("R7 result bipolar", 32'(result), 32'h9234);
        check("R7 format bipolar", 32'(result_bip), 32'd1);

        // R10 edge in the latch cycle
        run_conv(16'h3333, 1'b0, 1'b0, CONV, -1, cyc);
        check("R10 length", cyc, CONV);
        check("R10 result", 32'(result), 32'h3333);
        conv_r = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check("R10 no start while high", 32'(busy), 32'd0);
        end
        conv_r = 1'b0;
        @(negedge clk);
        run_conv(16'hC001, 1'b0, 1'b0, -1, -1, cyc);
        check("R10 fresh edge starts", 32'(result), 32'hC001);

        finish_run();
    end
endmodule